// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block maps a logical address, given as a segment number and an offset, to a physical address. It holds a small table of segment descriptors in registers. Each descriptor carries a present flag, a read-only flag, a limit and a base. A request is accepted only if the segment number is inside the table, the descriptor is present and the offset is below the limit. A write to a read-only descriptor is also refused. An accepted request returns the base plus the offset. A refused request returns an error code and no address.

A configuration port loads one descriptor per clock. The requester raises a strobe together with the segment number, the offset and a write flag. The answer appears on registered outputs in the next cycle. Segments shared between tasks are loaded read-only and keep the same segment number for every sharer. The protection check then keeps any one of them from changing the shared contents.

Top module: `seg_xlat`

## Requirements
- R1: After synchronous reset, rsp_vld is 0 and every descriptor is not present, so any request answers with error code 3.
- R2: rsp_vld is 1 exactly in the cycle after a cycle with req_vld high, and only then.
- R3: A legal request returns rsp_err = 0 and rsp_addr = base + offset of the addressed descriptor.
- R4: An offset equal to or greater than the descriptor's limit returns error code 1 (limit). An offset of limit-1 is legal.
- R5: A segment number at or beyond NUM_SEGS returns error code 3 (no segment), and configuration writes to such numbers change nothing.
- R6: A descriptor written with the present flag clear returns error code 3.
- R7: A write request (req_wr=1) to a descriptor with the read-only flag set returns error code 2 (protection). A read to that descriptor is translated normally.
- R8: The error codes rank as follows: no segment (3) above limit (1) above protection (2).
- R9: Whenever rsp_err is nonzero, rsp_addr is 0. In a cycle without a response, rsp_err and rsp_addr are 0.
- R10: A request made in the same cycle as a configuration write to its descriptor uses the old descriptor. The next request sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | SEG_W | Descriptor number to write |
| cfg_present | input | 1 | Present flag to store |
| cfg_ro | input | 1 | Read-only flag to store |
| cfg_limit | input | OFF_W | Segment length in words |
| cfg_base | input | ADDR_W | Segment start in physical space |
| req_vld | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_wr | input | 1 | 1 for a write access, 0 for a read |
| rsp_vld | output | 1 | Response valid, one cycle after req_vld |
| rsp_addr | output | ADDR_W | Physical address, 0 on error |
| rsp_err | output | 2 | 0 ok, 1 limit, 2 protection, 3 no segment |

## Verification
Reads of several descriptors check the adder against known sums, including the pair offset 1123 in segment 3 that gives 4623. Offsets of limit-1, limit and all ones test the comparison's edge and keep it apart from an off-by-one. Reads and writes to the same read-only descriptor, plus requests that break two rules at once, show that protection depends on the write flag and that the error ranking holds. A request in the same cycle as a rewrite of its descriptor, followed by an identical request, shows the old value is used and then the new one. Out-of-range, never-loaded and deliberately cleared descriptors show the no-segment code for all three causes.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  typedef enum logic [1:0] {
    XERR_NONE  = 2'd0,
    XERR_LIMIT = 2'd1,
    XERR_PROT  = 2'd2,
    XERR_NOSEG = 2'd3
  } xerr_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W    = 3,
  parameter int NUM_SEGS = 6,
  parameter int OFF_W    = 16,
  parameter int ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic              wr_present,
  input  logic              wr_ro,
  input  logic [OFF_W-1:0]  wr_limit,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic              rd_inrange,
  output logic              rd_present,
  output logic              rd_ro,
  output logic [OFF_W-1:0]  rd_limit,
  output logic [ADDR_W-1:0] rd_base
);
  localparam logic [SEG_W:0] SEG_LIM = (SEG_W+1)'(NUM_SEGS);

  logic [OFF_W-1:0]  limit_mem [NUM_SEGS];
  logic [ADDR_W-1:0] base_mem  [NUM_SEGS];
  logic              ro_mem    [NUM_SEGS];
  logic [NUM_SEGS-1:0] present_q;

  logic wr_ok;
  assign wr_ok = wr_en && ({1'b0, wr_idx} < SEG_LIM);

  // descriptor payload: no reset, RAM-style write port
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      limit_mem[wr_idx] <= wr_limit;
      base_mem[wr_idx]  <= wr_base;
      ro_mem[wr_idx]    <= wr_ro;
    end
  end

  // present flags need a defined reset state
  always_ff @(posedge clk) begin
    if (rst) present_q <= '0;
    else if (wr_ok) present_q[wr_idx] <= wr_present;
  end

  // asynchronous read sees the pre-write contents in a write cycle
  always_comb begin
    rd_inrange = ({1'b0, rd_idx} < SEG_LIM);
    rd_present = 1'b0;
    rd_ro      = 1'b0;
    rd_limit   = '0;
    rd_base    = '0;
    if (rd_inrange) begin
      rd_present = present_q[rd_idx];
      rd_ro      = ro_mem[rd_idx];
      rd_limit   = limit_mem[rd_idx];
      rd_base    = base_mem[rd_idx];
    end
  end

  // R1: after reset no descriptor is present
  assert_clear_R1: assert property (@(posedge clk) rst |=> present_q == '0);
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              inrange,
  input  logic              present,
  input  logic              ro,
  input  logic [OFF_W-1:0]  limit,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  input  logic              wr,
  output xerr_e             err,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] sum;
  assign sum = base + ADDR_W'(off);

  always_comb begin
    if (!inrange || !present) err = XERR_NOSEG;
    else if (off >= limit)    err = XERR_LIMIT;
    else if (wr && ro)        err = XERR_PROT;
    else                      err = XERR_NONE;
    addr = (err == XERR_NONE) ? sum : '0;
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int SEG_W    = 3,
  parameter int NUM_SEGS = 6,
  parameter int OFF_W    = 16,
  parameter int ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic              cfg_present,
  input  logic              cfg_ro,
  input  logic [OFF_W-1:0]  cfg_limit,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              req_vld,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_wr,
  output logic              rsp_vld,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [1:0]        rsp_err
);
  logic              t_inrange, t_present, t_ro;
  logic [OFF_W-1:0]  t_limit;
  logic [ADDR_W-1:0] t_base;
  xerr_e             c_err;
  logic [ADDR_W-1:0] c_addr;

  seg_table #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_present(cfg_present), .wr_ro(cfg_ro),
    .wr_limit(cfg_limit), .wr_base(cfg_base),
    .rd_idx(req_seg), .rd_inrange(t_inrange), .rd_present(t_present), .rd_ro(t_ro),
    .rd_limit(t_limit), .rd_base(t_base)
  );

  seg_check #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_check (
    .inrange(t_inrange), .present(t_present), .ro(t_ro), .limit(t_limit),
    .base(t_base), .off(req_off), .wr(req_wr), .err(c_err), .addr(c_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      rsp_addr <= '0;
      rsp_err  <= XERR_NONE;
    end else begin
      rsp_vld  <= req_vld;
      rsp_addr <= req_vld ? c_addr : '0;
      rsp_err  <= req_vld ? c_err  : XERR_NONE;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> (!rsp_vld && rsp_err == 2'd0 && rsp_addr == '0));
  assert_noaddr_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_err != 2'd0) |-> (rsp_addr == '0));
  assert_noseg_R5: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !t_inrange) |=> (rsp_err == 2'd3));
  assert_limit_R4: assert property (@(posedge clk) disable iff (rst)
    (req_vld && t_inrange && t_present && req_off >= t_limit) |=> (rsp_err == 2'd1));
  assert_prot_R7: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_wr && t_inrange && t_present && t_ro && req_off < t_limit)
      |=> (rsp_err == 2'd2));
endmodule

// File: tb/tb_seg_xlat.sv
module tb_seg_xlat;
  localparam int SEG_W = 3, NUM_SEGS = 6, OFF_W = 16, ADDR_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_present = 1'b0, cfg_ro = 1'b0;
  logic [SEG_W-1:0] cfg_idx = '0;
  logic [OFF_W-1:0] cfg_limit = '0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic req_vld = 1'b0, req_wr = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic rsp_vld;
  logic [ADDR_W-1:0] rsp_addr;
  logic [1:0] rsp_err;

  always #5 clk = ~clk;

  seg_xlat #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_present(cfg_present),
    .cfg_ro(cfg_ro), .cfg_limit(cfg_limit), .cfg_base(cfg_base), .req_vld(req_vld),
    .req_seg(req_seg), .req_off(req_off), .req_wr(req_wr), .rsp_vld(rsp_vld),
    .rsp_addr(rsp_addr), .rsp_err(rsp_err)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        err;
    string             tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic cfg_set(input int idx, input bit pres, input bit ro,
                         input int lim, input int base);
    cfg_we = 1'b1; cfg_idx = SEG_W'(idx); cfg_present = pres; cfg_ro = ro;
    cfg_limit = OFF_W'(lim); cfg_base = ADDR_W'(base);
  endtask

  task automatic req_set(input int seg, input int off, input bit wr,
                         input int ea, input int ee, input string tag);
    exp_t e;
    req_vld = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_wr = wr;
    e.addr = ADDR_W'(ea); e.err = 2'(ee); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
    cfg_we = 1'b0; req_vld = 1'b0;
  endtask

  task automatic xreq(input int seg, input int off, input bit wr,
                      input int ea, input int ee, input string tag);
    req_set(seg, off, wr, ea, ee, tag);
    step();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_vld) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R2: response with no request pending, actual addr=%0d err=%0d expected none",
                   rsp_addr, rsp_err);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rsp_addr !== e.addr || rsp_err !== e.err) begin
            errors++;
            $display("FAIL %s: actual addr=%0d err=%0d expected addr=%0d err=%0d",
                     e.tag, rsp_addr, rsp_err, e.addr, e.err);
          end
        end
      end else begin
        checks++;
        if (rsp_err !== 2'd0 || rsp_addr !== '0 || sb.size() > 1) begin
          errors++;
          $display("FAIL R9/R2: idle actual addr=%0d err=%0d pending=%0d expected 0 0 <=1",
                   rsp_addr, rsp_err, sb.size());
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: rsp_vld actual=%0b expected=0", rsp_vld);
    end
    rst = 1'b0;
    step();
    // R1: nothing present after reset
    xreq(0, 0, 0, 0, 3, "R1 empty table");
    // load test table; segment 1 read-only, 4/5 left empty
    cfg_set(0, 1, 0, 1500, 1000); step();
    cfg_set(1, 1, 1, 200, 5500); step();
    cfg_set(2, 1, 0, 700, 6000); step();
    cfg_set(3, 1, 0, 2000, 3500); step();
    cfg_set(6, 1, 0, 100, 100); step();   // R5: out of range write ignored
    xreq(3, 1123, 0, 4623, 0, "R3 seg3 off1123");
    xreq(0, 0, 0, 1000, 0, "R3 seg0 off0");
    xreq(3, 1999, 1, 5499, 0, "R3 seg3 write last");
    xreq(2, 699, 0, 6699, 0, "R4 limit-1");
    xreq(2, 700, 0, 0, 1, "R4 at limit");
    xreq(0, 1500, 0, 0, 1, "R4 seg0 at limit");
    xreq(0, 65535, 1, 0, 1, "R4 max offset");
    xreq(6, 0, 0, 0, 3, "R5 seg6");
    xreq(7, 5, 1, 0, 3, "R5 seg7");
    xreq(4, 0, 0, 0, 3, "R6 never loaded");
    xreq(1, 10, 1, 0, 2, "R7 write ro");
    xreq(1, 10, 0, 5510, 0, "R7 read ro");
    xreq(1, 300, 1, 0, 1, "R8 limit over prot");
    xreq(5, 60000, 1, 0, 3, "R8 noseg over limit");
    // back-to-back then a gap
    req_set(2, 1, 0, 6001, 0, "R2 back-to-back a"); step();
    req_set(0, 2, 1, 1002, 0, "R2 back-to-back b"); step();
    step();
    // R10: same-cycle rewrite uses old entry
    cfg_set(2, 1, 0, 100, 9000);
    req_set(2, 50, 0, 6050, 0, "R10 old entry");
    step();
    xreq(2, 50, 0, 9050, 0, "R10 new entry");
    xreq(2, 150, 0, 0, 1, "R10 new limit");
    // R6: clear present flag
    cfg_set(0, 0, 0, 1500, 1000); step();
    xreq(0, 0, 0, 0, 3, "R6 cleared");
    step(); step();
    done = 1'b1;
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: pending actual=%0d expected=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R2: watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule